// File: doc/BRIEF.md
# Low-Power Halt Mode Controller

This block decides what the chip does after the CPU core executes a halt instruction. One configuration bit, the oscillator interrupt enable, selects the flavour. With the bit set, the block enters an active halt: the main oscillator and the real-time wake-up counter keep running, and the CPU and the internally clocked peripherals are gated off. With the bit clear, it enters a plain halt, in which the oscillator is also stopped. The controller drives the four clock enables and forces the two-bit interrupt mask so that interrupts are open while the part sleeps. It also tells the watchdog whether sleeping is legal.

On wake-up the block picks the exit path. An interrupt that ends an active halt resumes the CPU at once, and the CPU services that interrupt. Every other exit first passes through a stabilisation count of `STAB_CYCLES` oscillator cycles: a reset-type wake from either halt, and any wake from plain halt. When the count ends, the CPU clock is released for a one-cycle resume phase. That phase reports either "service interrupt" or "fetch reset vector". A reset-type wake always takes precedence over an interrupt that arrives in the same cycle.

The state machine has five states: RUN, HALT (plain), ACTIVE_HALT, STABILISE and RESUME. It has these transitions:
- RUN→ACTIVE_HALT: halt request with the enable bit set.
- RUN→HALT: halt request with the enable bit clear.
- ACTIVE_HALT→RESUME: interrupt wake.
- ACTIVE_HALT→STABILISE: reset wake.
- HALT→STABILISE: any wake.
- STABILISE→STABILISE: a reset wake restarts the count.
- STABILISE→RESUME: the count is done.
- RESUME→RUN: always, after one cycle.

Top module: `lp_halt_ctrl`

## Requirements
- R1: When `halt_req` is high in RUN, the next cycle is ACTIVE_HALT if `osc_irq_en`=1 (`osc_en`=1, `rtc_en`=1, `cpu_en`=0, `periph_en`=0). Otherwise it is HALT, with all four enables at 0.
- R2: In ACTIVE_HALT, `imask_force`=1 and `imask_val`=2'b10. In every other state, `imask_force`=0 and `imask_val`=2'b00.
- R3: In ACTIVE_HALT, the following lead to RESUME in the next cycle, with `resume_irq`=1 and all enables at 1: `rtc_tick`, or any bit i of `ext_irq` with `WAKE_MASK[i]`=1. Bits with `WAKE_MASK[i]`=0 have no effect, and the state stays ACTIVE_HALT.
- R4: If `irq_pending` is high together with `halt_req` and `osc_irq_en`=1, ACTIVE_HALT lasts exactly one cycle and is followed by RESUME with `resume_irq`=1.
- R5: A `sys_rst_req` in HALT or ACTIVE_HALT leads to STABILISE for exactly `STAB_CYCLES` cycles (`osc_en`=1, `rtc_en`=1, `cpu_en`=0, `periph_en`=0). A one-cycle RESUME with `fetch_rst_vec`=1 follows.
- R6: In HALT, a wake-capable `ext_irq` bit leads to STABILISE for `STAB_CYCLES` cycles, then to RESUME with `resume_irq`=1. `rtc_tick` has no effect in HALT.
- R7: When `sys_rst_req` and an interrupt wake occur in the same cycle of a halt state, the reset path is taken.
- R8: A `sys_rst_req` during STABILISE restarts the full `STAB_CYCLES` count and switches the exit to `fetch_rst_vec`.
- R9: `wake_strobe` is high for exactly one cycle: the first cycle after a halt state is left.
- R10: In ACTIVE_HALT, `wdg_rst_suppress`=1 and `wdg_rst_req`=0. In HALT, `wdg_rst_req` equals `wdg_active`. In every other state, both are 0.
- R11: After `rst_n` is released the state is RUN. RESUME lasts one cycle and is followed by RUN. In RUN and RESUME all four enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| halt_req | input | 1 | One-cycle pulse: the CPU executed a halt |
| osc_irq_en | input | 1 | Oscillator interrupt enable; selects active halt |
| rtc_tick | input | 1 | Real-time counter interrupt |
| ext_irq | input | NUM_XIRQ | External interrupt lines |
| irq_pending | input | 1 | An interrupt is pending when the halt executes |
| sys_rst_req | input | 1 | Reset-type wake event |
| wdg_active | input | 1 | Watchdog is running |
| osc_en | output | 1 | Main oscillator enable |
| rtc_en | output | 1 | Wake-up counter clock enable |
| cpu_en | output | 1 | CPU clock enable |
| periph_en | output | 1 | Internally clocked peripheral clock enable |
| imask_force | output | 1 | Override the CPU interrupt-mask bits |
| imask_val | output | 2 | Forced interrupt-mask value |
| wake_strobe | output | 1 | One-cycle pulse after a wake |
| resume_irq | output | 1 | Resume: service the waking interrupt |
| fetch_rst_vec | output | 1 | Resume: fetch the reset vector |
| wdg_rst_suppress | output | 1 | Watchdog reset must be held off |
| wdg_rst_req | output | 1 | Request a reset: plain halt with the watchdog running |

## Verification
The bench builds the block with `STAB_CYCLES`=64, `NUM_XIRQ`=4 and `WAKE_MASK`=4'b0101. With the short count, the bench can run several complete stabilisation windows, including a restart in the middle of a window, within a small run. The mask leaves lines 1 and 3 not wake-capable, so the bench can show that such an interrupt leaves an active halt untouched. The count boundary is also exercised: the resume cycle must follow the 64th stabilise cycle exactly.

// File: rtl/lp_halt_pkg.sv
package lp_halt_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_HALT     = 3'd1,
        ST_ACT_HALT = 3'd2,
        ST_STAB     = 3'd3,
        ST_RESUME   = 3'd4
    } halt_state_t;

    localparam logic [1:0] IMASK_OPEN = 2'b10;

endpackage

// File: rtl/lp_wake_sel.sv
module lp_wake_sel #(
    parameter int                NUM_XIRQ  = 4,
    parameter logic [NUM_XIRQ-1:0] WAKE_MASK = '1
) (
    input  logic                active_mode,
    input  logic                rtc_tick,
    input  logic [NUM_XIRQ-1:0] ext_irq,
    input  logic                entry_pend,
    input  logic                sys_rst_req,
    output logic                irq_wake,
    output logic                rst_wake
);

    logic [NUM_XIRQ-1:0] ext_hit;

    for (genvar g = 0; g < NUM_XIRQ; g++) begin : g_line
        if (WAKE_MASK[g]) begin : g_cap
            assign ext_hit[g] = ext_irq[g];
        end else begin : g_blk
            assign ext_hit[g] = 1'b0;
        end
    end

    logic any_ext;
    assign any_ext = |ext_hit;

    always_comb begin
        if (active_mode) begin
            irq_wake = any_ext | rtc_tick | entry_pend;
        end else begin
            irq_wake = any_ext;
        end
        rst_wake = sys_rst_req;
    end

endmodule

// File: rtl/lp_stab_timer.sv
module lp_stab_timer #(
    parameter int STAB_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);

    localparam int CNT_W = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STAB_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run && !load && (cnt_q == '0);

endmodule

// File: rtl/lp_en_decode.sv
module lp_en_decode
    import lp_halt_pkg::*;
(
    input  halt_state_t state,
    input  logic        path_rst,
    input  logic        wdg_active,
    output logic        osc_en,
    output logic        rtc_en,
    output logic        cpu_en,
    output logic        periph_en,
    output logic        imask_force,
    output logic [1:0]  imask_val,
    output logic        resume_irq,
    output logic        fetch_rst_vec,
    output logic        wdg_rst_suppress,
    output logic        wdg_rst_req
);

    always_comb begin
        osc_en           = 1'b1;
        rtc_en           = 1'b1;
        cpu_en           = 1'b1;
        periph_en        = 1'b1;
        imask_force      = 1'b0;
        imask_val        = 2'b00;
        resume_irq       = 1'b0;
        fetch_rst_vec    = 1'b0;
        wdg_rst_suppress = 1'b0;
        wdg_rst_req      = 1'b0;
        unique case (state)
            ST_RUN: begin
            end
            ST_HALT: begin
                osc_en      = 1'b0;
                rtc_en      = 1'b0;
                cpu_en      = 1'b0;
                periph_en   = 1'b0;
                wdg_rst_req = wdg_active;
            end
            ST_ACT_HALT: begin
                cpu_en           = 1'b0;
                periph_en        = 1'b0;
                imask_force      = 1'b1;
                imask_val        = IMASK_OPEN;
                wdg_rst_suppress = 1'b1;
            end
            ST_STAB: begin
                cpu_en    = 1'b0;
                periph_en = 1'b0;
            end
            ST_RESUME: begin
                resume_irq    = !path_rst;
                fetch_rst_vec = path_rst;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/lp_halt_ctrl.sv
module lp_halt_ctrl
    import lp_halt_pkg::*;
#(
    parameter int                  STAB_CYCLES = 4096,
    parameter int                  NUM_XIRQ    = 4,
    parameter logic [NUM_XIRQ-1:0] WAKE_MASK   = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                halt_req,
    input  logic                osc_irq_en,
    input  logic                rtc_tick,
    input  logic [NUM_XIRQ-1:0] ext_irq,
    input  logic                irq_pending,
    input  logic                sys_rst_req,
    input  logic                wdg_active,
    output logic                osc_en,
    output logic                rtc_en,
    output logic                cpu_en,
    output logic                periph_en,
    output logic                imask_force,
    output logic [1:0]          imask_val,
    output logic                wake_strobe,
    output logic                resume_irq,
    output logic                fetch_rst_vec,
    output logic                wdg_rst_suppress,
    output logic                wdg_rst_req
);

    halt_state_t state_q, state_d;
    logic        path_rst_q, path_rst_d;
    logic        entry_pend_q, entry_pend_d;
    logic        wake_q, wake_d;
    logic        irq_wake, rst_wake;
    logic        stab_load, stab_done;
    logic        in_halt;

    assign in_halt = (state_q == ST_HALT) || (state_q == ST_ACT_HALT);

    lp_wake_sel #(
        .NUM_XIRQ  (NUM_XIRQ),
        .WAKE_MASK (WAKE_MASK)
    ) u_wake (
        .active_mode (state_q == ST_ACT_HALT),
        .rtc_tick    (rtc_tick),
        .ext_irq     (ext_irq),
        .entry_pend  (entry_pend_q),
        .sys_rst_req (sys_rst_req),
        .irq_wake    (irq_wake),
        .rst_wake    (rst_wake)
    );

    lp_stab_timer #(
        .STAB_CYCLES (STAB_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (stab_load),
        .run   (state_q == ST_STAB),
        .done  (stab_done)
    );

    always_comb begin
        state_d      = state_q;
        path_rst_d   = path_rst_q;
        entry_pend_d = entry_pend_q;
        wake_d       = 1'b0;
        stab_load    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (halt_req) begin
                    state_d      = osc_irq_en ? ST_ACT_HALT : ST_HALT;
                    entry_pend_d = osc_irq_en && irq_pending;
                end
            end
            ST_HALT: begin
                if (rst_wake || irq_wake) begin
                    state_d    = ST_STAB;
                    path_rst_d = rst_wake;
                    stab_load  = 1'b1;
                    wake_d     = 1'b1;
                end
            end
            ST_ACT_HALT: begin
                if (rst_wake) begin
                    state_d      = ST_STAB;
                    path_rst_d   = 1'b1;
                    stab_load    = 1'b1;
                    wake_d       = 1'b1;
                    entry_pend_d = 1'b0;
                end else if (irq_wake) begin
                    state_d      = ST_RESUME;
                    path_rst_d   = 1'b0;
                    wake_d       = 1'b1;
                    entry_pend_d = 1'b0;
                end
            end
            ST_STAB: begin
                if (rst_wake) begin
                    path_rst_d = 1'b1;
                    stab_load  = 1'b1;
                end else if (stab_done) begin
                    state_d = ST_RESUME;
                end
            end
            ST_RESUME: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_RUN;
            path_rst_q   <= 1'b0;
            entry_pend_q <= 1'b0;
            wake_q       <= 1'b0;
        end else begin
            state_q      <= state_d;
            path_rst_q   <= path_rst_d;
            entry_pend_q <= entry_pend_d;
            wake_q       <= wake_d;
        end
    end

    lp_en_decode u_dec (
        .state            (state_q),
        .path_rst         (path_rst_q),
        .wdg_active       (wdg_active),
        .osc_en           (osc_en),
        .rtc_en           (rtc_en),
        .cpu_en           (cpu_en),
        .periph_en        (periph_en),
        .imask_force      (imask_force),
        .imask_val        (imask_val),
        .resume_irq       (resume_irq),
        .fetch_rst_vec    (fetch_rst_vec),
        .wdg_rst_suppress (wdg_rst_suppress),
        .wdg_rst_req      (wdg_rst_req)
    );

    assign wake_strobe = wake_q;

    // R1
    active_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && halt_req && osc_irq_en) |=> (osc_en && rtc_en && !cpu_en && !periph_en));

    // R1
    plain_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && halt_req && !osc_irq_en) |=> (!osc_en && !rtc_en && !cpu_en));

    // R3
    rtc_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACT_HALT && rtc_tick && !sys_rst_req) |=> (resume_irq && cpu_en));

    // R7
    rst_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_halt && sys_rst_req) |=> (state_q == ST_STAB && !cpu_en));

    // R5
    stab_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stab_done |=> (state_q == ST_RESUME && cpu_en));

    // R11
    resume_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESUME) |=> (state_q == ST_RUN));

    // R9
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_strobe |=> !wake_strobe);

    // R10
    wdg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACT_HALT) |-> (wdg_rst_suppress && !wdg_rst_req));

endmodule

// File: tb/lp_halt_ctrl_tb.sv
`timescale 1ns/1ps
module lp_halt_ctrl_tb_top;

    localparam int          N_STAB = 64;
    localparam int          NX     = 4;
    localparam logic [3:0]  WMASK  = 4'b0101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req = 0, osc_irq_en = 0, rtc_tick = 0, irq_pending = 0;
    logic sys_rst_req = 0, wdg_active = 0;
    logic [NX-1:0] ext_irq = '0;
    logic osc_en, rtc_en, cpu_en, periph_en, imask_force, wake_strobe;
    logic resume_irq, fetch_rst_vec, wdg_rst_suppress, wdg_rst_req;
    logic [1:0] imask_val;

    always #2.5 clk = ~clk;

    lp_halt_ctrl #(.STAB_CYCLES(N_STAB), .NUM_XIRQ(NX), .WAKE_MASK(WMASK)) dut_i (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .osc_irq_en(osc_irq_en),
        .rtc_tick(rtc_tick), .ext_irq(ext_irq), .irq_pending(irq_pending),
        .sys_rst_req(sys_rst_req), .wdg_active(wdg_active),
        .osc_en(osc_en), .rtc_en(rtc_en), .cpu_en(cpu_en), .periph_en(periph_en),
        .imask_force(imask_force), .imask_val(imask_val), .wake_strobe(wake_strobe),
        .resume_irq(resume_irq), .fetch_rst_vec(fetch_rst_vec),
        .wdg_rst_suppress(wdg_rst_suppress), .wdg_rst_req(wdg_rst_req)
    );

    // behavioural model: mode 0 run, 1 halt, 2 active halt, 3 stabilise, 4 resume
    int    m_mode = 0;
    int    m_left = 0;
    bit    m_rstpath = 0, m_pend = 0, m_wake = 0;
    int    vectors = 0, miscompares = 0, cycles = 0;
    bit    finished = 0;
    string tag = "R11";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_rstpath = 0; m_pend = 0; m_wake = 0;
        end else begin
            bit ext_w;
            ext_w = (ext_irq & WMASK) != 0;
            m_wake = 0;
            case (m_mode)
                0: if (halt_req) begin
                       m_mode = osc_irq_en ? 2 : 1;
                       m_pend = osc_irq_en && irq_pending;
                   end
                1: if (sys_rst_req || ext_w) begin
                       m_rstpath = sys_rst_req; m_mode = 3; m_left = N_STAB; m_wake = 1;
                   end
                2: if (sys_rst_req) begin
                       m_rstpath = 1; m_mode = 3; m_left = N_STAB; m_wake = 1; m_pend = 0;
                   end else if (ext_w || rtc_tick || m_pend) begin
                       m_rstpath = 0; m_mode = 4; m_wake = 1; m_pend = 0;
                   end
                3: if (sys_rst_req) begin
                       m_rstpath = 1; m_left = N_STAB;
                   end else if (m_left == 1) m_mode = 4;
                   else m_left--;
                default: m_mode = 0;
            endcase
        end
    end

    task automatic cmp(input string req, input string nm, input int act, input int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!finished) begin
            bit run_like;
            run_like = (m_mode == 0) || (m_mode == 4);
            vectors++;
            cmp(tag, "osc_en", osc_en, m_mode != 1);
            cmp(tag, "rtc_en", rtc_en, m_mode != 1);
            cmp(tag, "cpu_en", cpu_en, run_like);
            cmp(tag, "periph_en", periph_en, run_like);
            cmp(tag, "resume_irq", resume_irq, m_mode == 4 && !m_rstpath);
            cmp(tag, "fetch_rst_vec", fetch_rst_vec, m_mode == 4 && m_rstpath);
            cmp("R2", "imask_force", imask_force, m_mode == 2);
            cmp("R2", "imask_val", imask_val, (m_mode == 2) ? 2 : 0);
            cmp("R9", "wake_strobe", wake_strobe, m_wake);
            cmp("R10", "wdg_rst_suppress", wdg_rst_suppress, m_mode == 2);
            cmp("R10", "wdg_rst_req", wdg_rst_req, m_mode == 1 && wdg_active);
            if (cycles > 20000) begin
                miscompares++;
                $display("FAIL watchdog expired act=%0d exp=%0d", cycles, 20000);
                finished = 1;
                $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic pulse_halt(input bit en, input bit pend);
        @(negedge clk); #1;
        halt_req = 1; osc_irq_en = en; irq_pending = pend;
        @(negedge clk); #1;
        halt_req = 0; irq_pending = 0;
    endtask

    task automatic pulse_ev(input bit rtc, input logic [NX-1:0] ext, input bit rst);
        @(negedge clk); #1;
        rtc_tick = rtc; ext_irq = ext; sys_rst_req = rst;
        @(negedge clk); #1;
        rtc_tick = 0; ext_irq = '0; sys_rst_req = 0;
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        // R11: reset state checked on idle cycles
        tag = "R11"; idle(4);
        // R1 R2 R3: active halt, non-wake line 1 ignored, then RTC wake
        tag = "R3"; pulse_halt(1, 0); idle(4);
        pulse_ev(0, 4'b1010, 0); idle(4);
        pulse_ev(1, '0, 0); idle(4);
        // R3: wake-capable line 2
        pulse_halt(1, 0); idle(2); pulse_ev(0, 4'b0100, 0); idle(4);
        // R4: pending at entry
        tag = "R4"; pulse_halt(1, 1); idle(5);
        // R6: plain halt, RTC ignored, line 0 wakes after full count
        tag = "R6"; pulse_halt(0, 0); idle(3); pulse_ev(1, '0, 0); idle(3);
        pulse_ev(0, 4'b0001, 0); idle(N_STAB + 5);
        // R5: reset wake from active halt
        tag = "R5"; pulse_halt(1, 0); idle(2); pulse_ev(0, '0, 1); idle(N_STAB + 5);
        // R7: reset and RTC together
        tag = "R7"; pulse_halt(1, 0); idle(2); pulse_ev(1, 4'b0001, 1); idle(N_STAB + 5);
        // R8: reset during stabilise restarts the count
        tag = "R8"; pulse_halt(0, 0); idle(2); pulse_ev(0, 4'b0100, 0);
        idle(10); pulse_ev(0, '0, 1); idle(N_STAB + 5);
        // R10: watchdog in both halts, R1 plain entry
        tag = "R10"; wdg_active = 1; pulse_halt(0, 0); idle(3); pulse_ev(0, '0, 1);
        idle(N_STAB + 5);
        tag = "R1"; pulse_halt(1, 0); idle(3); pulse_ev(1, '0, 0); idle(3);
        wdg_active = 0; idle(3);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule